// File: doc/BRIEF.md
# Reversing Barrel Shifter and Rotator

This block shifts or rotates an N-bit operand by any amount from 0 to N-1 within one combinational path. It has no clock and no reset. A 3-bit operation code selects one of six operations: logical, arithmetic or rotating moves, either right or left. The datapath contains only one right-moving logarithmic network. Left operations mirror the operand's bit order before that network and mirror the network's result afterwards.

A small decoder turns the operation code into a bundle of strobes for the datapath. A single fill bit is chosen ahead of the stages and is shared by every stage. Each stage takes its top positions either from that fill bit or from the wrapped low bits of its own input. For a left arithmetic shift, the fill is zero and the operand's sign bit is put back at the result's MSB.

Top module: `rev_barrel_shifter`

## Requirements
- R1: N is a power of two and the amount input is log2(N) bits wide. The operation code `op[2:0]` = {left, rotate, arith} means: 000 shift right logical, 001 shift right arithmetic, 010 and 011 rotate right, 100 shift left logical, 101 shift left arithmetic, 110 and 111 rotate left.
- R2: Shift right logical by B gives Y[i] = A[i+B] for i+B < N, and 0 for every other bit.
- R3: Shift right arithmetic by B gives Y[i] = A[i+B] for i+B < N, and A[N-1] for every other bit.
- R4: Rotate right by B gives Y[i] = A[(i+B) mod N], whatever the value of op[0].
- R5: Shift left logical by B gives Y[i] = A[i-B] for i >= B, and 0 for every other bit.
- R6: Shift left arithmetic by B gives zeros in the low B bits and Y[i] = A[i-B] for B <= i < N-1. Y[N-1] always equals A[N-1].
- R7: Rotate left by B gives Y[i] = A[(i-B) mod N], whatever the value of op[0].
- R8: An amount of zero returns Y = A for every operation code.
- R9: Y depends only on the present values of the inputs. With all inputs at zero, Y is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | N | Operand to be moved |
| amt | input | log2(N) | Shift or rotate distance |
| op | input | 3 | Operation code {left, rotate, arith} |
| res | output | N | Shifted or rotated result |

## Verification
The bench targets the bit positions where a fill bit meets the moved data. It uses operands with the sign bit set, because a design that fills with zero, or that applies the right-shift sign fill to left shifts, corrupts exactly those positions. Left arithmetic shifts use operands whose bit N-2 differs from the sign, so a design that forgets to restore the MSB, or restores the wrong bit, shows a flipped top bit. Rotates are run with both values of the don't-care bit and with every amount, so a fault in a wrap connection or in a single stage select shows up at some distance. At width 8 every operand, amount and code is applied, so a fault confined to one mux of the reversal rows cannot escape.

// File: rtl/rev_shift_pkg.sv
package rev_shift_pkg;

  typedef enum logic [2:0] {
    OP_SRL  = 3'b000,
    OP_SRA  = 3'b001,
    OP_ROR0 = 3'b010,
    OP_ROR1 = 3'b011,
    OP_SLL  = 3'b100,
    OP_SLA  = 3'b101,
    OP_ROL0 = 3'b110,
    OP_ROL1 = 3'b111
  } shiftOpT;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic mirror;    // reverse data into and out of the right core
    logic wrap;      // stages take wrapped low bits instead of fill
    logic signFill;  // fill with operand MSB (right arithmetic only)
    logic keepSign;  // force result MSB to operand MSB (left arithmetic)
  } shiftCtrlT;

endpackage

// File: rtl/rev_shift_ctrl.sv
module rev_shift_ctrl
  import rev_shift_pkg::*;
(
  input  logic [2:0] op,
  output shiftCtrlT  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (shiftOpT'(op))
      OP_SRL:           ctrl = '0;
      OP_SRA:           ctrl.signFill = 1'b1;
      OP_ROR0, OP_ROR1: ctrl.wrap = 1'b1;
      OP_SLL:           ctrl.mirror = 1'b1;
      OP_SLA: begin
        ctrl.mirror   = 1'b1;
        ctrl.keepSign = 1'b1;
      end
      OP_ROL0, OP_ROL1: begin
        ctrl.mirror = 1'b1;
        ctrl.wrap   = 1'b1;
      end
      default:          ctrl = '0;
    endcase
  end

  // R1: the two arithmetic strobes never appear together, and neither with wrap
  always_comb begin
    a_r1_arith_strobes_exclusive: assert ($onehot0({ctrl.signFill, ctrl.keepSign}));
    a_r1_wrap_not_arith: assert (!(ctrl.wrap && (ctrl.signFill || ctrl.keepSign)));
  end

endmodule

// File: rtl/rev_shift_datapath.sv
module rev_shift_datapath
  import rev_shift_pkg::*;
#(
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic [N-1:0]  opnd,
  input  logic [AW-1:0] amt,
  input  shiftCtrlT     ctrl,
  output logic [N-1:0]  res
);

  logic [N-1:0]       opndRev;
  logic [N-1:0]       coreIn;
  logic [AW:0][N-1:0] stg;
  logic [N-1:0]       coreRev;
  logic [N-1:0]       preFix;
  logic               fillBit;

  // input mirror row
  for (genvar i = 0; i < N; i++) begin : g_inRev
    assign opndRev[i] = opnd[N-1-i];
  end
  assign coreIn  = ctrl.mirror ? opndRev : opnd;
  assign fillBit = ctrl.signFill ? opnd[N-1] : 1'b0;
  assign stg[0]  = coreIn;

  // logarithmic right core: stage k moves by 2**k when amt[k] is set
  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int D = 1 << k;
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic moved;
      if (i < N - D) begin : g_inner
        assign moved = stg[k][i+D];
      end else begin : g_top
        assign moved = ctrl.wrap ? stg[k][i+D-N] : fillBit;
      end
      assign stg[k+1][i] = amt[k] ? moved : stg[k][i];
    end
  end

  // output mirror row
  for (genvar i = 0; i < N; i++) begin : g_outRev
    assign coreRev[i] = stg[AW][N-1-i];
  end
  assign preFix = ctrl.mirror ? coreRev : stg[AW];
  assign res    = {ctrl.keepSign ? opnd[N-1] : preFix[N-1], preFix[N-2:0]};

  always_comb begin
    // R8: zero distance is identity for every code
    a_r8_zero_amount_identity: assert (amt != '0 || res == opnd);
    // R4/R7: rotation preserves the number of ones
    a_r4_rotate_keeps_ones: assert (!ctrl.wrap || $countones(res) == $countones(opnd));
    // R3: right arithmetic keeps the sign at the top
    a_r3_sra_sign_top: assert (!ctrl.signFill || res[N-1] == opnd[N-1]);
    // R6: left arithmetic keeps the sign at the top
    a_r6_sla_sign_top: assert (!ctrl.keepSign || res[N-1] == opnd[N-1]);
    // R2: a nonzero logical right shift clears the MSB
    a_r2_srl_top_clear: assert (ctrl.mirror || ctrl.wrap || ctrl.signFill ||
                                amt == '0 || res[N-1] == 1'b0);
    // R5: a nonzero logical left shift clears the LSB
    a_r5_sll_bottom_clear: assert (!ctrl.mirror || ctrl.wrap || amt == '0 ||
                                   res[0] == 1'b0);
  end

endmodule

// File: rtl/rev_barrel_shifter.sv
module rev_barrel_shifter
  import rev_shift_pkg::*;
#(
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic [N-1:0]  opnd,
  input  logic [AW-1:0] amt,
  input  logic [2:0]    op,
  output logic [N-1:0]  res
);

  shiftCtrlT ctrl;

  // R1: width must be a power of two, at least 2
  initial begin
    a_r1_width_pow2: assert (N >= 2 && (1 << AW) == N);
  end

  rev_shift_ctrl i_ctrl (
    .op   (op),
    .ctrl (ctrl)
  );

  rev_shift_datapath #(.N(N)) i_dp (
    .opnd (opnd),
    .amt  (amt),
    .ctrl (ctrl),
    .res  (res)
  );

  // R9: all-zero inputs give a zero result
  always_comb begin
    a_r9_zero_in_zero_out: assert (!(opnd == '0 && amt == '0 && op == 3'b000) || res == '0);
  end

endmodule

// File: tb/test_rev_barrel_shifter.sv
module test_rev_barrel_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors  = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  logic [31:0] a32;
  logic [4:0]  b32;
  logic [2:0]  op32;
  logic [31:0] y32;
  logic [7:0]  a8;
  logic [2:0]  b8;
  logic [2:0]  op8;
  logic [7:0]  y8;

  rev_barrel_shifter #(.N(32)) i_rev_barrel_shifter (
    .opnd(a32), .amt(b32), .op(op32), .res(y32)
  );
  rev_barrel_shifter #(.N(8)) i_rev_barrel_shifter_w8 (
    .opnd(a8), .amt(b8), .op(op8), .res(y8)
  );

  // behavioural model built from the requirement text
  function automatic logic [31:0] refModel(logic [31:0] a, int w, int b, logic [2:0] op);
    logic [31:0] y = '0;
    for (int i = 0; i < w; i++) begin
      case (op)
        3'b000: y[i] = (i + b < w) ? a[i+b] : 1'b0;
        3'b001: y[i] = (i + b < w) ? a[i+b] : a[w-1];
        3'b010, 3'b011: y[i] = a[(i + b) % w];
        3'b100, 3'b101: y[i] = (i >= b) ? a[i-b] : 1'b0;
        default: y[i] = a[(i - b + w) % w];
      endcase
    end
    if (op == 3'b101) y[w-1] = a[w-1];
    return y;
  endfunction

  function automatic string reqOf(logic [2:0] op);
    case (op)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010, 3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply32(logic [31:0] a, int b, logic [2:0] op, string req);
    logic [31:0] exp;
    @(negedge clk);
    a32 = a; b32 = 5'(b); op32 = op;
    #1;
    exp = refModel(a, 32, b, op);
    vectors++;
    if (y32 !== exp) begin
      failures++;
      $display("FAIL %s w32 op=%b a=%h b=%0d actual=%h expected=%h", req, op, a, b, y32, exp);
    end
  endtask

  task automatic apply8(logic [7:0] a, int b, logic [2:0] op, string req);
    logic [31:0] exp;
    @(negedge clk);
    a8 = a; b8 = 3'(b); op8 = op;
    #1;
    exp = refModel({24'h0, a}, 8, b, op);
    vectors++;
    if (y8 !== exp[7:0]) begin
      failures++;
      $display("FAIL %s w8 op=%b a=%h b=%0d actual=%h expected=%h", req, op, a, b, y8, exp[7:0]);
    end
  endtask

  // R9: zero inputs, result present without any clock edge
  task automatic testIdle();
    apply32(32'h0, 0, 3'b000, "R9");
    apply8(8'h0, 0, 3'b000, "R9");
  endtask

  task automatic testRightLogical();
    for (int b = 0; b < 32; b++) apply32(32'hF00D_8001, b, 3'b000, "R2");
  endtask

  task automatic testRightArith();
    for (int b = 0; b < 32; b++) apply32(32'h8000_0001, b, 3'b001, "R3");
    for (int b = 0; b < 32; b++) apply32(32'h7FFF_FFFE, b, 3'b001, "R3");
  endtask

  task automatic testRotateRight();
    for (int b = 0; b < 32; b++) begin
      apply32(32'h8000_0003, b, 3'b010, "R4");
      apply32(32'h8000_0003, b, 3'b011, "R4");
    end
  endtask

  task automatic testLeftLogical();
    for (int b = 0; b < 32; b++) apply32(32'h8001_0C35, b, 3'b100, "R5");
  endtask

  task automatic testLeftArith();
    for (int b = 0; b < 32; b++) begin
      apply32(32'h4000_0001, b, 3'b101, "R6");
      apply32(32'hBFFF_FFFF, b, 3'b101, "R6");
    end
  endtask

  task automatic testRotateLeft();
    for (int b = 0; b < 32; b++) begin
      apply32(32'hC000_0001, b, 3'b110, "R7");
      apply32(32'hC000_0001, b, 3'b111, "R7");
    end
  endtask

  task automatic testZeroAmount();
    for (int op = 0; op < 8; op++) apply32(32'hDEAD_BEEF, 0, 3'(op), "R8");
  endtask

  // R1: every code and amount at width 8, all operands
  task automatic testExhaustive8();
    for (int op = 0; op < 8; op++)
      for (int b = 0; b < 8; b++)
        for (int a = 0; a < 256; a++)
          apply8(8'(a), b, 3'(op), reqOf(3'(op)));
  endtask

  task automatic testRandom32();
    for (int n = 0; n < 16; n++)
      for (int op = 0; op < 8; op++)
        for (int b = 0; b < 32; b++)
          apply32($urandom(), b, 3'(op), reqOf(3'(op)));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG_CYCLES);
      finishRun();
    end
  end

  initial begin
    a32 = '0; b32 = '0; op32 = '0;
    a8 = '0; b8 = '0; op8 = '0;
    testIdle();
    testRightLogical();
    testRightArith();
    testRotateRight();
    testLeftLogical();
    testLeftArith();
    testRotateLeft();
    testZeroAmount();
    testExhaustive8();
    testRandom32();
    finishRun();
  end

endmodule